// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces one pulse-width-modulated output for a display backlight. Software sets it up through a small synchronous register bus. A prescaler divides the input clock into ticks. A period counter counts ticks, and the output stays high while that counter is below the programmed high width. The prescaler, period and high-width settings are written into shadow registers first.

In buffered operation, the shadow settings reach the active counter only after a commit. The transfer waits for the end of the running period, so the output never shows a shortened or merged pulse. If the output is disabled when the commit arrives, the transfer happens at once. A direct mode lets each shadow write take effect on the following cycle. This mode is useful for bring-up and for firmware that does not use commits. An enable bit gates the output and restarts both counters.

Top module: `bklt_pwm`

## Requirements
- R1: With the output enabled, one output period lasts (pre + 1) × (per + 1) clock cycles. Here pre is the active prescaler value and per is the active period value.
- R2: The output is high for hi × (pre + 1) cycles at the start of each period. A high width of 0 keeps the output low.
- R3: A high width of per + 1 or more keeps the output high for the whole period.
- R4: Bit 0 of the enable register (byte address 0x00) turns the output on. With this bit at 0 the output is low and both counters hold at zero, so every enable starts a full period. Bits 31:1 of a write to this register are ignored.
- R5: Register map:
  - 0x04: commit bit in bit 0.
  - 0x08: prescaler in bits 25:16 and the direct-select bit in bit 1.
  - 0x0C: period in bits 11:0 and high width in bits 28:16.
  - 0x10: bypass field in bits 1:0.
  - Reads return the stored (shadow) values, and all unused bits read as zero.
- R6: In buffered mode, writes to 0x08 and 0x0C change only the shadow registers. They do not change the output until a commit. A commit is a write that changes the commit bit from 0 to 1.
- R7: A commit that arrives while the output is enabled is applied at the end of the current period. A commit written during the last cycle of a period takes effect in the very next period.
- R8: A commit that arrives while the output is disabled is applied on the same clock edge.
- R9: Direct mode needs both conditions: the bypass field equals 3 and the direct-select bit is 1. In this mode a shadow write reaches the counter one cycle after it lands. Any other combination keeps buffered mode.
- R10: After reset every register is zero and the output is low.
- R11: The prescaler supports its full 10-bit range, up to a division by 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte address of the register accessed |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 1 | PWM output |

## Verification
A commit write and the last cycle of a period can fall in the same clock cycle. In that case the pending transfer and the period wrap must resolve together. The bench starts a five-cycle period and times the commit write so that it is sampled on the final cycle of the first period. It then judges the outcome by counting high cycles: the period before the commit shows the old width and the period after it shows the new one. A second case places the commit in mid-period and checks that the old width holds until the wrap.

// File: rtl/bklt_pwm_pkg.sv
`timescale 1ns/1ps
package bklt_pwm_pkg;

  // Register byte addresses
  localparam int REG_EN     = 'h00;
  localparam int REG_COMMIT = 'h04;
  localparam int REG_CTL0   = 'h08;
  localparam int REG_CTL1   = 'h0C;
  localparam int REG_BYP    = 'h10;

  // Field positions inside the 32-bit data word
  localparam int PRE_LSB = 16;
  localparam int HI_LSB  = 16;
  localparam int PER_LSB = 0;
  localparam int SEL_BIT = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;   // output enabled, counters advance
    logic load;  // copy shadow settings into the active set
  } dpStrb_t;

endpackage

// File: rtl/bklt_pwm_ctrl.sv
`timescale 1ns/1ps
module bklt_pwm_ctrl
  import bklt_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 10,
  parameter int PER_W  = 12,
  parameter int HI_W   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata,
  input  logic              periodEnd,
  output dpStrb_t           strb,
  output logic [PRE_W-1:0]  shPre,
  output logic [PER_W-1:0]  shPer,
  output logic [HI_W-1:0]   shHi
);

  localparam int BYP_W = 2;
  localparam logic [BYP_W-1:0] BYP_ALL = '1;

  logic             enReg;
  logic             commitBit;
  logic             selBit;
  logic [BYP_W-1:0] bypass;
  logic             pending;

  logic hitEn, hitCommit, hitCtl0, hitCtl1, hitByp;
  logic commitReq, directMode, pendNow, loadNow;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;

  assign hitEn     = busAddr == ADDR_W'(REG_EN);
  assign hitCommit = busAddr == ADDR_W'(REG_COMMIT);
  assign hitCtl0   = busAddr == ADDR_W'(REG_CTL0);
  assign hitCtl1   = busAddr == ADDR_W'(REG_CTL1);
  assign hitByp    = busAddr == ADDR_W'(REG_BYP);

  // A commit is the 0 -> 1 transition of the stored commit bit
  assign commitReq  = busWe && hitCommit && busWdata[0] && !commitBit;
  assign directMode = (bypass == BYP_ALL) && selBit;
  assign pendNow    = pending || commitReq;
  assign loadNow    = directMode || (pendNow && (periodEnd || !enReg));

  assign strb.run  = enReg;
  assign strb.load = loadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      commitBit <= 1'b0;
      selBit    <= 1'b0;
      bypass    <= '0;
      shPre     <= '0;
      shPer     <= '0;
      shHi      <= '0;
      pending   <= 1'b0;
    end else begin
      if (busWe && hitEn)     enReg     <= busWdata[0];
      if (busWe && hitCommit) commitBit <= busWdata[0];
      if (busWe && hitCtl0) begin
        shPre  <= busWdata[PRE_LSB +: PRE_W];
        selBit <= busWdata[SEL_BIT];
      end
      if (busWe && hitCtl1) begin
        shPer <= busWdata[PER_LSB +: PER_W];
        shHi  <= busWdata[HI_LSB +: HI_W];
      end
      if (busWe && hitByp) bypass <= busWdata[BYP_W-1:0];
      pending <= pendNow && !loadNow;
    end
  end

  // Read path: shadow contents, unused bits zero
  always_comb begin
    busRdata = '0;
    if (hitEn)     busRdata[0] = enReg;
    if (hitCommit) busRdata[0] = commitBit;
    if (hitCtl0) begin
      busRdata[PRE_LSB +: PRE_W] = shPre;
      busRdata[SEL_BIT]          = selBit;
    end
    if (hitCtl1) begin
      busRdata[PER_LSB +: PER_W] = shPer;
      busRdata[HI_LSB +: HI_W]   = shHi;
    end
    if (hitByp) busRdata[BYP_W-1:0] = bypass;
  end

  // R7: an enabled, buffered commit stays pending until the period ends
  a_r7_hold_pending : assert property (@(posedge clk) disable iff (!rstN)
    (pending && enReg && !periodEnd && !directMode && !(busWe && hitEn))
      |=> pending);

  // R8: a pending commit does not survive a cycle with the output disabled
  a_r8_apply_when_off : assert property (@(posedge clk) disable iff (!rstN)
    (pendNow && !enReg) |=> !pending);

  // R9: direct mode never leaves a commit waiting
  a_r9_direct_no_pend : assert property (@(posedge clk) disable iff (!rstN)
    directMode |=> !pending);

  // R5: top bits of every readback are zero
  a_r5_top_bits_zero : assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:29] == 3'b000);

endmodule

// File: rtl/bklt_pwm_dp.sv
`timescale 1ns/1ps
module bklt_pwm_dp
  import bklt_pwm_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  input  logic [PRE_W-1:0] shPre,
  input  logic [PER_W-1:0] shPer,
  input  logic [HI_W-1:0]  shHi,
  output logic             periodEnd,
  output logic             pwmOut
);

  localparam int CMP_W = ((PER_W > HI_W) ? PER_W : HI_W) + 1;

  logic [PRE_W-1:0] actPre, preCnt;
  logic [PER_W-1:0] actPer, perCnt;
  logic [HI_W-1:0]  actHi;
  logic             tick;

  // >= so a period shortened in direct mode wraps at once
  assign tick      = strb.run && (preCnt >= actPre);
  assign periodEnd = tick && (perCnt >= actPer);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPre <= '0;
      actPer <= '0;
      actHi  <= '0;
    end else if (strb.load) begin
      actPre <= shPre;
      actPer <= shPer;
      actHi  <= shHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!strb.run) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      perCnt <= periodEnd ? '0 : perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign pwmOut = strb.run && (CMP_W'(perCnt) < CMP_W'(actHi));

  // R1: the cycle after a period end starts a fresh period
  a_r1_wrap_to_zero : assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (perCnt == '0 && preCnt == '0));

  // R2: a zero high width never drives the output high
  a_r2_zero_width_low : assert property (@(posedge clk) disable iff (!rstN)
    (actHi == '0) |-> !pwmOut);

  // R4: disabled output is low and counters restart
  a_r4_off_low : assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> !pwmOut);
  a_r4_off_restart : assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (perCnt == '0));

endmodule

// File: rtl/bklt_pwm.sv
`timescale 1ns/1ps
module bklt_pwm
  import bklt_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 10,
  parameter int PER_W  = 12,
  parameter int HI_W   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata,
  output logic              pwmOut
);

  dpStrb_t          strb;
  logic             periodEnd;
  logic [PRE_W-1:0] shPre;
  logic [PER_W-1:0] shPer;
  logic [HI_W-1:0]  shHi;

  bklt_pwm_ctrl #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W), .PER_W(PER_W), .HI_W(HI_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata),
    .periodEnd(periodEnd), .strb(strb),
    .shPre(shPre), .shPer(shPer), .shHi(shHi)
  );

  bklt_pwm_dp #(
    .PRE_W(PRE_W), .PER_W(PER_W), .HI_W(HI_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .shPre(shPre), .shPer(shPer), .shHi(shHi),
    .periodEnd(periodEnd), .pwmOut(pwmOut)
  );

endmodule

// File: tb/bklt_pwm_test.sv
`timescale 1ns/1ps
module bklt_pwm_test;

  localparam logic [7:0] A_EN = 8'h00, A_CM = 8'h04, A_C0 = 8'h08,
                         A_C1 = 8'h0C, A_BP = 8'h10;

  // {pre, per, hi, expected highs over two periods, first fall, first rise after fall}
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{0,    9, 3,    6,    3,    10},
    '{1,    4, 2,    8,    4,    10},
    '{2,    3, 0,    0,    0,    0},
    '{0,    5, 6,    12,   0,    0},
    '{3,    2, 8,    24,   0,    0},
    '{0,    0, 1,    2,    0,    0},
    '{1023, 1, 1,    2048, 1024, 2048},
    '{4,    7, 5,    50,   25,   40}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        pwmOut;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bklt_pwm uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setup(input int pre, input int per, input int hi);
    wr(A_EN, 0);
    wr(A_C0, pre << 16);
    wr(A_C1, (hi << 16) | per);
    wr(A_CM, 1);
    wr(A_CM, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int highs, h1, h2;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 out low in reset", pwmOut, 0);
    rstN = 1'b1;
    rd(A_EN, d);  chk("R10 enable zero", d, 0);
    rd(A_C0, d);  chk("R10 ctl0 zero", d, 0);
    rd(A_C1, d);  chk("R10 ctl1 zero", d, 0);
    // R5 readback masks
    wr(A_C0, 32'hFFFF_FFFF); rd(A_C0, d); chk("R5 ctl0 mask", d, 32'h03FF_0002);
    wr(A_C1, 32'hFFFF_FFFF); rd(A_C1, d); chk("R5 ctl1 mask", d, 32'h1FFF_0FFF);
    wr(A_BP, 32'hFFFF_FFFF); rd(A_BP, d); chk("R5 bypass mask", d, 3);
    wr(A_BP, 0); wr(A_C0, 0); wr(A_C1, 0);
    // R4 upper enable bits ignored
    wr(A_C1, (4 << 16) | 5); wr(A_CM, 1); wr(A_CM, 0);
    wr(A_EN, 32'hFFFF_FFFE);
    chk("R4 ignored bits keep out low", pwmOut, 0);
    rd(A_EN, d); chk("R4 ignored bits read", d, 0);

    // R1 R2 R3 R11: vector table
    for (int v = 0; v < NV; v++) begin
      int w, ff, fr;
      bit prev;
      setup(VEC[v][0], VEC[v][1], VEC[v][2]);
      wr(A_EN, 1);
      w = 2 * (VEC[v][0] + 1) * (VEC[v][1] + 1);
      highs = 0; ff = 0; fr = 0; prev = 1'b0;
      for (int k = 0; k < w; k++) begin
        highs += int'(pwmOut);
        if (k > 0 && prev && !pwmOut && ff == 0) ff = k;
        if (k > 0 && !prev && pwmOut && ff != 0 && fr == 0) fr = k;
        prev = pwmOut;
        @(negedge clk);
      end
      chk($sformatf("R2 R3 R11 vec%0d high count", v), highs, VEC[v][3]);
      chk($sformatf("R2 vec%0d first fall", v), ff, VEC[v][4]);
      chk($sformatf("R1 vec%0d period start", v), fr, VEC[v][5]);
    end

    // R4 disable forces low
    setup(0, 3, 9);
    wr(A_EN, 1);
    chk("R4 enabled high", pwmOut, 1);
    wr(A_EN, 0);
    chk("R4 disable forces low", pwmOut, 0);

    // R6 R7 mid-period commit deferred
    setup(0, 9, 3);
    wr(A_C1, (7 << 16) | 9);
    rd(A_C1, d); chk("R5 shadow readback", d, 32'h0007_0009);
    wr(A_EN, 1);
    h1 = 0; h2 = 0;
    for (int k = 0; k < 20; k++) begin
      if (k < 10) h1 += int'(pwmOut); else h2 += int'(pwmOut);
      if (k == 4) begin busAddr = A_CM; busWdata = 1; busWe = 1'b1; end
      if (k == 5) busWe = 1'b0;
      @(negedge clk);
    end
    chk("R6 R7 old width until period end", h1, 3);
    chk("R7 new width next period", h2, 7);
    wr(A_CM, 0);

    // R7 commit on the last cycle of a period
    setup(0, 4, 1);
    wr(A_C1, (3 << 16) | 4);
    wr(A_EN, 1);
    h1 = 0; h2 = 0;
    for (int k = 0; k < 10; k++) begin
      if (k < 5) h1 += int'(pwmOut); else h2 += int'(pwmOut);
      if (k == 4) begin busAddr = A_CM; busWdata = 1; busWe = 1'b1; end
      if (k == 5) busWe = 1'b0;
      @(negedge clk);
    end
    chk("R7 boundary old period", h1, 1);
    chk("R7 boundary next period new width", h2, 3);
    wr(A_CM, 0);

    // R9 direct mode
    wr(A_EN, 0);
    wr(A_BP, 3);
    wr(A_C0, 2);
    wr(A_C1, (3 << 16) | 9);
    wr(A_EN, 1);
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      highs += int'(pwmOut);
      if (k == 1) begin busAddr = A_C1; busWdata = (7 << 16) | 9; busWe = 1'b1; end
      if (k == 2) busWe = 1'b0;
      @(negedge clk);
    end
    chk("R9 direct write takes effect", highs, 7);

    // R9 bypass without select stays buffered
    wr(A_EN, 0);
    wr(A_C0, 0);
    wr(A_C1, (3 << 16) | 9);
    wr(A_CM, 1); wr(A_CM, 0);
    wr(A_C1, (7 << 16) | 9);
    wr(A_EN, 1);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      highs += int'(pwmOut);
      @(negedge clk);
    end
    chk("R9 bypass alone keeps buffering", highs, 6);
    wr(A_BP, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule